// File: doc/BRIEF.md
# March X Memory Self-Test Engine

This block is a built-in self-test controller for a word-addressed, single-port RAM. When started, it takes over the RAM's address, write-data, write-enable and read-enable lines. It runs the four-element March X sequence over a lower address window and then over an upper window. This covers the stuck-at, transition, unlinked inversion coupling and address decoder faults that can arise within one window. A test of the memory can therefore be split around a region that must not be overwritten while it is live, such as a stack, which is tested in its own pass.

Each word that is read back is compared with the all-zeros or the all-ones word of the configured data width. The first word that differs ends the run. The engine then holds the failing address, the element number, the window index and the data it read until the next start. A separate pass flag is raised for each window.

Top module: `march_x_bist`

## Requirements
- R1: The first element writes the all-zeros word to every address of the window, one write per cycle, from the low bound up to the high bound. Each address is written exactly three times over the whole sequence.
- R2: The second element visits addresses in ascending order. At each address it issues a read, compares the result with all-zeros, and then writes all-ones to the same address, which makes 3 cycles per word.
- R3: The third element starts at the high bound and visits addresses in descending order. At each address it reads and expects all-ones, and then writes all-zeros, which makes 3 cycles per word.
- R4: The fourth element reads each address in ascending order and expects all-zeros, which makes 2 cycles per word. Each address is read exactly three times over the whole sequence.
- R5: Read data is sampled on the cycle after `mem_re`. Write enable and read enable are never asserted together, and no write is issued in the cycle that follows a read.
- R6: The first miscompare raises `fail` and `done` together, drops `busy`, and stops all further RAM access.
- R7: On a failure the engine holds the failing address, the element number (1 to 4), the window index (0 for the lower window, 1 for the upper) and the word that was read.
- R8: By default the lower window covers 0x00 to 0xEF and the upper window covers 0xF0 to the top address, and the two run back to back. `pass1` rises 9 × N0 cycles after the start edge, and `pass2` and `done` rise 9 × (N0 + N1) cycles after it, where N is the number of words in a window.
- R9: Coupling between cells in different windows is not covered. An aggressor in the upper window that inverts a victim in the lower window does not cause a failure.
- R10: A start accepted while the engine is idle or finished clears `done`, `fail`, `pass1`, `pass2` and the captured fields on the next edge. A start seen while `busy` is ignored.
- R11: After reset `busy`, `done`, `fail`, `pass1`, `pass2`, `mem_we` and `mem_re` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a test run (accepted when not busy) |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable; data is expected one cycle later |
| mem_rdata | input | DATA_W | RAM read data |
| busy | output | 1 | Test sequence in progress |
| done | output | 1 | Run finished, by passing or failing |
| pass1 | output | 1 | Lower window passed |
| pass2 | output | 1 | Upper window passed |
| fail | output | 1 | A miscompare was found |
| fail_addr | output | ADDR_W | Address of the failing word |
| fail_elem | output | 3 | Element that failed, 1 to 4 |
| fail_part | output | 1 | Window that failed |
| fail_data | output | DATA_W | Word that was read at the failure |

## Verification
The properties assume that the RAM is synchronous: `mem_rdata` changes only on the edge after a cycle with `mem_re` high, and it holds its value otherwise. The checks that compare the captured fault data and address with the previous cycle's bus rely on this. They also assume that `start` is the only input that affects control. The bench's RAM model registers its read data only on an enabled read. It injects its stuck-at, transition and coupling faults through that path and the write path alone. The bench changes `start` only at falling edges, so the engine sees every start as a clean one-cycle pulse or a level.

// File: rtl/march_x_pkg.sv
package march_x_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FILL,
      ST_READ,
      ST_CHECK,
      ST_BACK,
      ST_END
   } mx_state_t;

   typedef enum logic [1:0] {
      EL_FILL0   = 2'd0,
      EL_UP_R0W1 = 2'd1,
      EL_DN_R1W0 = 2'd2,
      EL_UP_R0   = 2'd3
   } mx_elem_t;

   localparam int NUM_WIN = 2;

endpackage

// File: rtl/march_x_window.sv
module march_x_window #(
   parameter int ADDR_W = 8,
   parameter int LO     = 0,
   parameter int HI     = -1
) (
   output logic [ADDR_W-1:0] lo,
   output logic [ADDR_W-1:0] hi
);
   localparam int TOP = (1 << ADDR_W) - 1;

   assign lo = ADDR_W'(LO);

   generate
      if (HI < 0) begin : g_to_top
         assign hi = ADDR_W'(TOP);
      end else begin : g_fixed
         assign hi = ADDR_W'(HI);
      end
   endgenerate

endmodule

// File: rtl/march_x_seq.sv
module march_x_seq
   import march_x_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int W0_LO  = 0,
   parameter int W0_HI  = 239,
   parameter int W1_LO  = 240,
   parameter int W1_HI  = -1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              miscmp,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata,
   output logic              we,
   output logic              re,
   output logic [DATA_W-1:0] expect_w,
   output logic              chk,
   output logic [1:0]        elem,
   output logic              part,
   output logic              launch,
   output logic              part_ok,
   output logic              busy
);
   localparam logic [DATA_W-1:0] ONES  = '1;
   localparam logic [DATA_W-1:0] ZEROS = '0;

   logic [ADDR_W-1:0] win_lo [NUM_WIN];
   logic [ADDR_W-1:0] win_hi [NUM_WIN];

   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
         march_x_window #(
            .ADDR_W (ADDR_W),
            .LO     ((w == 0) ? W0_LO : W1_LO),
            .HI     ((w == 0) ? W0_HI : W1_HI)
         ) u_win (
            .lo (win_lo[w]),
            .hi (win_hi[w])
         );
      end
   endgenerate

   mx_state_t         st_q, st_d;
   mx_elem_t          el_q, el_d;
   logic              pt_q, pt_d;
   logic [ADDR_W-1:0] ad_q, ad_d;
   logic [ADDR_W-1:0] lo, hi;
   logic              adv;

   assign lo = win_lo[pt_q];
   assign hi = win_hi[pt_q];

   always_comb begin
      st_d    = st_q;
      el_d    = el_q;
      pt_d    = pt_q;
      ad_d    = ad_q;
      adv     = 1'b0;
      launch  = 1'b0;
      part_ok = 1'b0;
      case (st_q)
         ST_IDLE, ST_END: begin
            if (start) begin
               launch = 1'b1;
               st_d   = ST_FILL;
               el_d   = EL_FILL0;
               pt_d   = 1'b0;
               ad_d   = win_lo[0];
            end
         end
         ST_FILL: begin
            if (ad_q == hi) begin
               el_d = EL_UP_R0W1;
               ad_d = lo;
               st_d = ST_READ;
            end else begin
               ad_d = ad_q + 1'b1;
            end
         end
         ST_READ:  st_d = ST_CHECK;
         ST_CHECK: begin
            if (miscmp)              st_d = ST_END;
            else if (el_q != EL_UP_R0) st_d = ST_BACK;
            else                     adv  = 1'b1;
         end
         ST_BACK:  adv  = 1'b1;
         default:  st_d = ST_IDLE;
      endcase

      if (adv) begin
         st_d = ST_READ;
         case (el_q)
            EL_UP_R0W1: begin
               if (ad_q == hi) el_d = EL_DN_R1W0;
               else            ad_d = ad_q + 1'b1;
            end
            EL_DN_R1W0: begin
               if (ad_q == lo) el_d = EL_UP_R0;
               else            ad_d = ad_q - 1'b1;
            end
            EL_UP_R0: begin
               if (ad_q == hi) begin
                  part_ok = 1'b1;
                  if (pt_q) begin
                     st_d = ST_END;
                  end else begin
                     pt_d = 1'b1;
                     el_d = EL_FILL0;
                     ad_d = win_lo[1];
                     st_d = ST_FILL;
                  end
               end else begin
                  ad_d = ad_q + 1'b1;
               end
            end
            default: st_d = ST_END;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         el_q <= EL_FILL0;
         pt_q <= 1'b0;
         ad_q <= '0;
      end else begin
         st_q <= st_d;
         el_q <= el_d;
         pt_q <= pt_d;
         ad_q <= ad_d;
      end
   end

   assign addr     = ad_q;
   assign we       = (st_q == ST_FILL) || (st_q == ST_BACK);
   assign re       = (st_q == ST_READ);
   assign chk      = (st_q == ST_CHECK);
   assign wdata    = ((st_q == ST_BACK) && (el_q == EL_UP_R0W1)) ? ONES : ZEROS;
   assign expect_w = (el_q == EL_DN_R1W0) ? ONES : ZEROS;
   assign elem     = el_q;
   assign part     = pt_q;
   assign busy     = (st_q != ST_IDLE) && (st_q != ST_END);

endmodule

// File: rtl/march_x_judge.sv
module march_x_judge #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              chk,
   input  logic [DATA_W-1:0] expect_w,
   input  logic [DATA_W-1:0] rdata,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        elem,
   input  logic              part,
   input  logic              part_ok,
   output logic              miscmp,
   output logic              pass1,
   output logic              pass2,
   output logic              fail,
   output logic              done,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [2:0]        fail_elem,
   output logic              fail_part,
   output logic [DATA_W-1:0] fail_data
);
   logic [DATA_W-1:0] diff;

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign diff[b] = rdata[b] ^ expect_w[b];
      end
   endgenerate

   assign miscmp = chk && (|diff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass1     <= 1'b0;
         pass2     <= 1'b0;
         fail      <= 1'b0;
         done      <= 1'b0;
         fail_addr <= '0;
         fail_elem <= '0;
         fail_part <= 1'b0;
         fail_data <= '0;
      end else if (clear) begin
         pass1     <= 1'b0;
         pass2     <= 1'b0;
         fail      <= 1'b0;
         done      <= 1'b0;
         fail_addr <= '0;
         fail_elem <= '0;
         fail_part <= 1'b0;
         fail_data <= '0;
      end else if (miscmp) begin
         fail      <= 1'b1;
         done      <= 1'b1;
         fail_addr <= addr;
         fail_elem <= {1'b0, elem} + 3'd1;
         fail_part <= part;
         fail_data <= rdata;
      end else if (part_ok) begin
         if (part) begin
            pass2 <= 1'b1;
            done  <= 1'b1;
         end else begin
            pass1 <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/march_x_bist.sv
module march_x_bist #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int W0_LO  = 0,
   parameter int W0_HI  = 239,
   parameter int W1_LO  = 240,
   parameter int W1_HI  = -1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              pass1,
   output logic              pass2,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [2:0]        fail_elem,
   output logic              fail_part,
   output logic [DATA_W-1:0] fail_data
);
   localparam int TOP   = (1 << ADDR_W) - 1;
   localparam int HI1   = (W1_HI < 0) ? TOP : W1_HI;

   generate
      if (ADDR_W < 2 || ADDR_W > 24) begin : g_bad_aw
         $error("march_x_bist: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("march_x_bist: DATA_W must be positive");
      end
      if (W0_LO < 0 || W0_LO > W0_HI || W0_HI > TOP) begin : g_bad_w0
         $error("march_x_bist: lower window bounds invalid");
      end
      if (W1_LO <= W0_HI || W1_LO > HI1 || HI1 > TOP) begin : g_bad_w1
         $error("march_x_bist: upper window bounds invalid or overlapping");
      end
   endgenerate

   logic              miscmp, chk, launch, part_ok, part;
   logic [1:0]        elem;
   logic [DATA_W-1:0] expect_w;

   march_x_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .W0_LO  (W0_LO),
      .W0_HI  (W0_HI),
      .W1_LO  (W1_LO),
      .W1_HI  (W1_HI)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .miscmp   (miscmp),
      .addr     (mem_addr),
      .wdata    (mem_wdata),
      .we       (mem_we),
      .re       (mem_re),
      .expect_w (expect_w),
      .chk      (chk),
      .elem     (elem),
      .part     (part),
      .launch   (launch),
      .part_ok  (part_ok),
      .busy     (busy)
   );

   march_x_judge #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_judge (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (launch),
      .chk       (chk),
      .expect_w  (expect_w),
      .rdata     (mem_rdata),
      .addr      (mem_addr),
      .elem      (elem),
      .part      (part),
      .part_ok   (part_ok),
      .miscmp    (miscmp),
      .pass1     (pass1),
      .pass2     (pass2),
      .fail      (fail),
      .done      (done),
      .fail_addr (fail_addr),
      .fail_elem (fail_elem),
      .fail_part (fail_part),
      .fail_data (fail_data)
   );

endmodule

// File: rtl/march_x_bist_chk.sv
module march_x_bist_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_we,
   input logic              mem_re,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              busy,
   input logic              done,
   input logic              pass1,
   input logic              pass2,
   input logic              fail,
   input logic [ADDR_W-1:0] fail_addr,
   input logic [2:0]        fail_elem,
   input logic              fail_part,
   input logic [DATA_W-1:0] fail_data
);
   // R5: one port operation per cycle
   assert_no_rw_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   // R5: the compare completes before any write follows a read
   assert_write_after_compare_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> !mem_we);

   // R1, R2, R3: only the two background words are ever written
   assert_write_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata == '0 || mem_wdata == '1));

   // R6: a failure ends the run
   assert_fail_ends_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> (done && !busy));

   // R6: no RAM access after a failure until restarted
   assert_silent_after_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> (!mem_we && !mem_re));

   // R7: captured fields come from the compare cycle
   assert_capture_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> (fail_addr == $past(mem_addr) && fail_data == $past(mem_rdata)));

   // R7: element number lies in 1..4 when failed, fields cleared otherwise
   assert_elem_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (fail_elem >= 3'd1 && fail_elem <= 3'd4));
   assert_fields_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fail |-> (fail_elem == 3'd0 && !fail_part && fail_addr == '0));

   // R8: upper window only passes after the lower one
   assert_pass_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pass2 |-> (pass1 && done && !fail));

   // R10: accepted start clears results
   assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done && !fail && !pass1 && !pass2));

   // R11: busy and done are exclusive
   assert_busy_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

endmodule

bind march_x_bist march_x_bist_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .mem_rdata (mem_rdata),
   .busy      (busy),
   .done      (done),
   .pass1     (pass1),
   .pass2     (pass2),
   .fail      (fail),
   .fail_addr (fail_addr),
   .fail_elem (fail_elem),
   .fail_part (fail_part),
   .fail_data (fail_data)
);

// File: tb/sim_march_x_bist.sv
`timescale 1ns/1ps
module sim_march_x_bist;
   localparam int AW = 8;
   localparam int DW = 8;
   localparam int N0 = 240;
   localparam int N1 = 16;
   localparam int T_P1  = 9 * N0;
   localparam int T_ALL = 9 * (N0 + N1);

   // kind: 0 none, 1 stuck-at-1 bit, 2 stuck-at-0 bit,
   //       3 inversion coupling (rising write of fa inverts word fb),
   //       4 bit cannot fall (down transition fault)
   typedef struct packed {
      int kind; int fa; int fb; int bitn;
      int efail; int eelem; int epart; int eaddr; int edata; int ecyc;
   } vec_t;

   localparam vec_t VEC [10] = '{
      '{0, 0,    0,    0, 0, 0, 0, 0,    0,    T_ALL},
      '{1, 32,   0,    3, 1, 2, 0, 32,   8,    338},
      '{2, 122,  0,    6, 1, 3, 0, 122,  191,  1313},
      '{1, 243,  0,    0, 1, 2, 1, 243,  1,    2187},
      '{2, 255,  0,    7, 1, 3, 1, 255,  127,  2226},
      '{1, 0,    0,    7, 1, 2, 0, 0,    128,  242},
      '{3, 5,    10,   0, 1, 2, 0, 10,   255,  272},
      '{3, 10,   5,    0, 1, 3, 0, 5,    0,    1664},
      '{3, 245,  5,    0, 0, 0, 0, 0,    0,    T_ALL},
      '{4, 51,   0,    2, 1, 4, 0, 51,   4,    1784}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we, mem_re;
   logic [DW-1:0] mem_rdata;
   logic busy, done, pass1, pass2, fail, fail_part;
   logic [AW-1:0] fail_addr;
   logic [2:0]    fail_elem;
   logic [DW-1:0] fail_data;

   always #4 clk = ~clk;

   march_x_bist u0 (
      .clk (clk), .rst_n (rst_n), .start (start),
      .mem_addr (mem_addr), .mem_wdata (mem_wdata),
      .mem_we (mem_we), .mem_re (mem_re), .mem_rdata (mem_rdata),
      .busy (busy), .done (done), .pass1 (pass1), .pass2 (pass2),
      .fail (fail), .fail_addr (fail_addr), .fail_elem (fail_elem),
      .fail_part (fail_part), .fail_data (fail_data)
   );

   // RAM model with fault injection
   logic [DW-1:0] mem [256];
   int wcnt [256];
   int rcnt [256];
   int acc, overlap_err, hold_err;
   int f_kind, f_a, f_b, f_bit;
   logic wipe = 1'b0;
   logic prev_re;

   function automatic logic [DW-1:0] rd_fault(input logic [DW-1:0] v, input int a);
      logic [DW-1:0] m;
      m = DW'(1) << f_bit;
      if (a == f_a && f_kind == 1) return v | m;
      if (a == f_a && f_kind == 2) return v & ~m;
      return v;
   endfunction

   always @(posedge clk) begin
      if (wipe) begin
         for (int i = 0; i < 256; i++) begin
            mem[i] = '0; wcnt[i] = 0; rcnt[i] = 0;
         end
         acc = 0; overlap_err = 0; hold_err = 0;
         prev_re <= 1'b0;
         mem_rdata <= '0;
      end else begin
         logic [DW-1:0] old;
         if (mem_we && mem_re) overlap_err++;
         if (mem_we && prev_re) hold_err++;
         prev_re <= mem_re;
         if (mem_re) begin
            mem_rdata <= rd_fault(mem[mem_addr], int'(mem_addr));
            rcnt[mem_addr]++;
            acc++;
         end
         if (mem_we) begin
            old = mem[mem_addr];
            mem[mem_addr] = mem_wdata;
            if (f_kind == 4 && int'(mem_addr) == f_a)
               mem[mem_addr] = mem_wdata | (old & (DW'(1) << f_bit));
            if (f_kind == 3 && int'(mem_addr) == f_a && old != mem_wdata && mem_wdata == '1)
               mem[f_b] = ~mem[f_b];
            wcnt[mem_addr]++;
            acc++;
         end
      end
   end

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic prep(input int k, input int a, input int b, input int bn);
      @(negedge clk);
      f_kind = k; f_a = a; f_b = b; f_bit = bn;
      wipe = 1'b1;
      @(negedge clk);
      wipe = 1'b0;
   endtask

   // start, then count cycles until done; optional second start mid-run
   task automatic run(output int cyc, output int p1cyc, input int poke);
      cyc = 0; p1cyc = 0;
      @(negedge clk) start = 1'b1;
      @(posedge clk);
      @(negedge clk) start = 1'b0;
      check("R10", {31'd0, busy}, 1, "busy after start");
      check("R10", {29'd0, fail, done, pass1}, 0, "results cleared after start");
      while (cyc < 4000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         start = (cyc == poke);
         if (pass1 && p1cyc == 0) p1cyc = cyc;
         if (done) break;
      end
      start = 1'b0;
   endtask

   initial begin
      #(8 * 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int cyc, p1cyc, a0;
      f_kind = 0; f_a = 0; f_b = 0; f_bit = 0;
      repeat (3) @(negedge clk);
      wipe = 1'b1;
      @(negedge clk);
      wipe = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      check("R11", {26'd0, busy, done, pass1, pass2, fail, mem_we}, 0, "idle flags");
      check("R11", {31'd0, mem_re}, 0, "read enable idle");

      // vector table
      for (int v = 0; v < 10; v++) begin
         vec_t t;
         t = VEC[v];
         prep(t.kind, t.fa, t.fb, t.bitn);
         run(cyc, p1cyc, -1);
         check("R8", cyc, t.ecyc, $sformatf("v%0d cycles to done", v));
         check("R6", {31'd0, fail}, t.efail, $sformatf("v%0d fail flag", v));
         check("R8", {31'd0, pass2}, (t.efail == 0) ? 1 : 0, $sformatf("v%0d pass2", v));
         check("R8", p1cyc, (t.efail == 0 || t.epart == 1) ? T_P1 : 0, $sformatf("v%0d pass1 cycle", v));
         check("R6", {31'd0, busy}, 0, $sformatf("v%0d busy at end", v));
         if (t.efail != 0) begin
            check("R7", int'(fail_addr), t.eaddr, $sformatf("v%0d fail address", v));
            check("R7", int'(fail_elem), t.eelem, $sformatf("v%0d fail element", v));
            check("R7", {31'd0, fail_part}, t.epart, $sformatf("v%0d fail window", v));
            check("R7", int'(fail_data), t.edata, $sformatf("v%0d fail data", v));
            a0 = acc;
            repeat (4) @(negedge clk);
            check("R6", acc, a0, $sformatf("v%0d accesses after fail", v));
         end else begin
            int wbad, rbad;
            wbad = 0; rbad = 0;
            for (int i = 0; i < 256; i++) begin
               if (wcnt[i] != 3) wbad++;
               if (rcnt[i] != 3) rbad++;
            end
            check("R1", wbad, 0, $sformatf("v%0d addresses not written 3 times (R2 R3)", v));
            check("R4", rbad, 0, $sformatf("v%0d addresses not read 3 times", v));
            if (t.kind == 3)
               check("R9", int'(mem[t.fb]), 255, "cross-window victim left corrupted");
         end
         check("R5", overlap_err, 0, $sformatf("v%0d read/write overlap", v));
         check("R5", hold_err, 0, $sformatf("v%0d write right after read", v));
      end

      // R10: start while busy is ignored
      prep(0, 0, 0, 0);
      run(cyc, p1cyc, 1000);
      check("R10", cyc, T_ALL, "cycles with mid-run start");
      check("R10", {31'd0, pass2}, 1, "pass2 with mid-run start");

      // R10: restart after a failed run clears captured fields
      prep(1, 250, 0, 1);
      run(cyc, p1cyc, -1);
      check("R7", int'(fail_addr), 250, "fail address before restart");
      prep(0, 0, 0, 0);
      @(negedge clk) start = 1'b1;
      @(posedge clk);
      @(negedge clk) start = 1'b0;
      check("R10", int'(fail_addr) + int'(fail_elem) + int'(fail_data), 0, "captured fields cleared");
      while (!done) @(negedge clk);
      check("R8", {30'd0, pass1, pass2}, 3, "both windows pass after restart");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule